// File: doc/BRIEF.md
# Segment Access-Mode Address Classifier

This block sorts a 32-bit virtual address into one of six configurable address segments and decides, for the requesting privilege level, whether the access is an address error, must be translated by the TLB, or passes straight through unmapped. Each segment is described by a 16-bit control half taken from one of three 32-bit control words. The half carries a 3-bit access-mode code, an error-level unmapped flag and a 7-bit physical base.

For an unmapped access the block also builds the physical address. It takes the segment's base, clears the bits that lie under the segment's offset mask, and merges in the address bits that lie under that mask. The class and the physical address are registered, so a lookup costs one clock. A pipeline stage ahead of the TLB uses the class to route the request to the TLB, to the memory path, or to the exception logic.

Top module: `seg_classifier`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `out_class` = 0 and `out_paddr` = 0, whatever the other inputs are.
- R2: The outputs present at any time reflect the inputs sampled at the most recent rising edge, a latency of exactly one cycle. They do not change between edges.
- R3: A control half is the upper bits [31:16] or the lower bits [15:0] of a control word. Within a half, bits [15:9] are the physical base, bits [6:4] are the access mode (AM) and bit 3 is the error-level unmapped flag (EU). The half used depends on the address range. Addresses below 0x40000000 use the upper half of `seg_ctl2`. Addresses from 0x40000000 to 0x7FFFFFFF use the lower half of `seg_ctl2`. 0x80000000 to 0x9FFFFFFF use the upper half of `seg_ctl1`, and 0xA0000000 to 0xBFFFFFFF use its lower half. 0xC0000000 to 0xDFFFFFFF use the upper half of `seg_ctl0`, and 0xE0000000 and above use its lower half.
- R4: With `priv` = 0 (kernel), AM 1, 2 and 3 give mapped. AM 0, 4, 5 and 7 give unmapped. Kernel never raises an address error except for AM 6.
- R5: With `priv` = 1 (supervisor), AM 0 and 1 give an address error. AM 2, 3 and 4 give mapped. AM 5 and 7 give unmapped.
- R6: With `priv` = 2 (user), or the unused code 3, AM 0, 1, 2 and 5 give an address error. AM 3 and 4 give mapped. AM 7 gives unmapped.
- R7: AM 6 is reserved and gives an address error at every privilege level.
- R8: When `err_level` is high and the selected half has EU set, the result is unmapped. This overrides R4 to R7. EU has no effect while `err_level` is low, and `err_level` has no effect on a half whose EU is clear.
- R9: For an unmapped result, `out_paddr` (36 bits) is the base shifted left by 29, with its segment-offset bits cleared, ORed with the address bits under the offset mask. The offset mask is 0x3FFFFFFF for addresses below 0x80000000 and 0x1FFFFFFF for all other addresses.
- R10: `out_class` is 0 for unmapped, 1 for mapped and 2 for address error, and is never 3. `out_paddr` is 0 whenever the class is not unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 32 | Virtual address to classify |
| priv | input | 2 | Privilege level: 0 kernel, 1 supervisor, 2 or 3 user |
| err_level | input | 1 | Error-level state flag |
| seg_ctl0 | input | 32 | Control halves for 0xC0000000 and above |
| seg_ctl1 | input | 32 | Control halves for 0x80000000 to 0xBFFFFFFF |
| seg_ctl2 | input | 32 | Control halves for addresses below 0x80000000 |
| out_class | output | 2 | 0 unmapped, 1 mapped, 2 address error |
| out_paddr | output | 36 | Physical address for unmapped results, else 0 |

## Verification
Both results, the class and the physical address, become valid one rising edge after the inputs are applied, because a single register stage sits between the decode and the ports. The bench changes inputs only on the falling edge, waits for the next rising edge, and samples a nanosecond later, so each check lands in the cycle where its result first appears. The latency test also samples just before the following rising edge, after new inputs are already driven, to show that the outputs still hold the previous result.

// File: rtl/segcls_pkg.sv
package segcls_pkg;

    localparam int VA_W        = 32;
    localparam int HALF_W      = 16;
    localparam int BASE_W      = 7;
    localparam int BASE_LSB    = 9;
    localparam int AM_W        = 3;
    localparam int MAP_SHIFT   = 8;

    localparam logic [AM_W-1:0] AM_RESERVED = 3'd6;

    localparam logic [31:0] GATE_KERN = 32'h7000_0000;
    localparam logic [31:0] GATE_SUPV = 32'hC038_0000;
    localparam logic [31:0] GATE_USER = 32'hE418_0000;

    localparam logic [VA_W-1:0] OFS_WIDE   = 32'h3FFF_FFFF;
    localparam logic [VA_W-1:0] OFS_NARROW = 32'h1FFF_FFFF;

    typedef enum logic [1:0] {
        CLS_UNMAPPED = 2'd0,
        CLS_MAPPED   = 2'd1,
        CLS_ADDRERR  = 2'd2
    } seg_class_e;

    typedef enum logic [1:0] {
        LVL_KERN = 2'd0,
        LVL_SUPV = 2'd1,
        LVL_USER = 2'd2,
        LVL_SPARE = 2'd3
    } priv_lvl_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [1:0]        rsvd_hi;
        logic [AM_W-1:0]   am;
        logic              eu;
        logic [2:0]        rsvd_lo;
    } seg_half_t;

    typedef struct packed {
        seg_half_t half;
        logic      wide;
    } seg_pick_t;

    function automatic logic [31:0] gate_for(input priv_lvl_e lvl);
        case (lvl)
            LVL_KERN: return GATE_KERN;
            LVL_SUPV: return GATE_SUPV;
            default:  return GATE_USER;
        endcase
    endfunction

    function automatic seg_half_t split_half(input logic [31:0] word, input logic upper);
        return upper ? seg_half_t'(word[31:16]) : seg_half_t'(word[15:0]);
    endfunction

endpackage

// File: rtl/seg_select.sv
module seg_select
    import segcls_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic [31:0]     ctl0,
    input  logic [31:0]     ctl1,
    input  logic [31:0]     ctl2,
    output seg_pick_t       pick
);
    always_comb begin
        pick = '0;
        unique case (vaddr[31:29])
            3'b000, 3'b001: begin pick.half = split_half(ctl2, 1'b1); pick.wide = 1'b1; end
            3'b010, 3'b011: begin pick.half = split_half(ctl2, 1'b0); pick.wide = 1'b1; end
            3'b100:         begin pick.half = split_half(ctl1, 1'b1); pick.wide = 1'b0; end
            3'b101:         begin pick.half = split_half(ctl1, 1'b0); pick.wide = 1'b0; end
            3'b110:         begin pick.half = split_half(ctl0, 1'b1); pick.wide = 1'b0; end
            default:        begin pick.half = split_half(ctl0, 1'b0); pick.wide = 1'b0; end
        endcase
    end
endmodule

// File: rtl/seg_access_decode.sv
module seg_access_decode
    import segcls_pkg::*;
(
    input  logic [AM_W-1:0] am,
    input  logic            eu,
    input  priv_lvl_e       lvl,
    input  logic            err_level,
    output seg_class_e      cls
);
    logic [31:0] gate;
    logic [4:0]  err_idx;
    logic [4:0]  map_idx;
    logic        err_hit;
    logic        map_hit;

    always_comb begin
        gate    = gate_for(lvl);
        err_idx = 5'd31 - {2'b00, am};
        map_idx = (lvl == LVL_KERN) ? err_idx : (err_idx - 5'(MAP_SHIFT));
        err_hit = (lvl != LVL_KERN) && gate[err_idx];
        map_hit = gate[map_idx];

        if (err_level && eu)
            cls = CLS_UNMAPPED;
        else if (am == AM_RESERVED)
            cls = CLS_ADDRERR;
        else if (err_hit)
            cls = CLS_ADDRERR;
        else if (map_hit)
            cls = CLS_MAPPED;
        else
            cls = CLS_UNMAPPED;
    end
endmodule

// File: rtl/seg_paddr_form.sv
module seg_paddr_form
    import segcls_pkg::*;
#(
    parameter int PA_SHIFT = 20
) (
    input  logic [VA_W-1:0]              vaddr,
    input  seg_pick_t                    pick,
    output logic [HALF_W+PA_SHIFT-1:0]   paddr
);
    localparam int PW  = HALF_W + PA_SHIFT;
    localparam int EXT = PW - VA_W;

    logic [PW-1:0] base;
    logic [PW-1:0] ofs_mask;
    logic [PW-1:0] va_ext;

    always_comb begin
        base     = {pick.half.base, {(BASE_LSB + PA_SHIFT){1'b0}}};
        ofs_mask = {{EXT{1'b0}}, (pick.wide ? OFS_WIDE : OFS_NARROW)};
        va_ext   = {{EXT{1'b0}}, vaddr};
        paddr    = (base & ~ofs_mask) | (va_ext & ofs_mask);
    end
endmodule

// File: rtl/seg_classifier.sv
module seg_classifier
    import segcls_pkg::*;
#(
    parameter int PA_SHIFT = 20
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [31:0]                vaddr,
    input  logic [1:0]                 priv,
    input  logic                       err_level,
    input  logic [31:0]                seg_ctl0,
    input  logic [31:0]                seg_ctl1,
    input  logic [31:0]                seg_ctl2,
    output logic [1:0]                 out_class,
    output logic [HALF_W+PA_SHIFT-1:0] out_paddr
);
    localparam int PW = HALF_W + PA_SHIFT;

    seg_pick_t     pick;
    seg_class_e    cls_d;
    seg_class_e    cls_q;
    logic [PW-1:0] pa_raw;
    logic [PW-1:0] pa_d;
    logic [PW-1:0] pa_q;

    seg_select u_sel (
        .vaddr (vaddr),
        .ctl0  (seg_ctl0),
        .ctl1  (seg_ctl1),
        .ctl2  (seg_ctl2),
        .pick  (pick)
    );

    seg_access_decode u_dec (
        .am        (pick.half.am),
        .eu        (pick.half.eu),
        .lvl       (priv_lvl_e'(priv)),
        .err_level (err_level),
        .cls       (cls_d)
    );

    seg_paddr_form #(.PA_SHIFT(PA_SHIFT)) u_pa (
        .vaddr (vaddr),
        .pick  (pick),
        .paddr (pa_raw)
    );

    always_comb pa_d = (cls_d == CLS_UNMAPPED) ? pa_raw : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= CLS_UNMAPPED;
            pa_q  <= '0;
        end else begin
            cls_q <= cls_d;
            pa_q  <= pa_d;
        end
    end

    assign out_class = cls_q;
    assign out_paddr = pa_q;
endmodule

// File: rtl/seg_classifier_chk.sv
module seg_classifier_chk #(
    parameter int PA_SHIFT = 20
) (
    input logic                  clk,
    input logic                  rst,
    input logic [31:0]           vaddr,
    input logic [1:0]            priv,
    input logic                  err_level,
    input logic [31:0]           seg_ctl0,
    input logic [31:0]           seg_ctl1,
    input logic [31:0]           seg_ctl2,
    input logic [1:0]            out_class,
    input logic [PA_SHIFT+15:0]  out_paddr
);
    logic primed;
    logic all_eu;
    logic all_rsvd;
    logic any_rsvd;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    always_comb begin
        all_eu   = seg_ctl0[19] & seg_ctl0[3] & seg_ctl1[19] & seg_ctl1[3]
                 & seg_ctl2[19] & seg_ctl2[3];
        all_rsvd = (seg_ctl0[22:20] == 3'd6) && (seg_ctl0[6:4] == 3'd6)
                && (seg_ctl1[22:20] == 3'd6) && (seg_ctl1[6:4] == 3'd6)
                && (seg_ctl2[22:20] == 3'd6) && (seg_ctl2[6:4] == 3'd6);
        any_rsvd = (seg_ctl0[22:20] == 3'd6) || (seg_ctl0[6:4] == 3'd6)
                || (seg_ctl1[22:20] == 3'd6) || (seg_ctl1[6:4] == 3'd6)
                || (seg_ctl2[22:20] == 3'd6) || (seg_ctl2[6:4] == 3'd6);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (out_class == 2'd0 && out_paddr == '0));

    assert_class_legal_R10: assert property (@(posedge clk) disable iff (rst)
        out_class != 2'd3);

    assert_paddr_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (out_class != 2'd0) |-> (out_paddr == '0));

    assert_offset_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (primed && out_class == 2'd0) |-> (out_paddr[28:0] == $past(vaddr[28:0])));

    assert_eu_override_R8: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(err_level) && $past(all_eu)) |-> (out_class == 2'd0));

    assert_reserved_err_R7: assert property (@(posedge clk) disable iff (rst)
        (primed && !$past(err_level) && $past(all_rsvd)) |-> (out_class == 2'd2));

    assert_kernel_no_err_R4: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(priv) == 2'd0 && !$past(any_rsvd)) |-> (out_class != 2'd2));
endmodule

bind seg_classifier seg_classifier_chk #(.PA_SHIFT(PA_SHIFT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vaddr     (vaddr),
    .priv      (priv),
    .err_level (err_level),
    .seg_ctl0  (seg_ctl0),
    .seg_ctl1  (seg_ctl1),
    .seg_ctl2  (seg_ctl2),
    .out_class (out_class),
    .out_paddr (out_paddr)
);

// File: tb/seg_classifier_test.sv
module seg_classifier_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] vaddr = '0;
    logic [1:0]  priv = '0;
    logic        err_level = 1'b0;
    logic [31:0] seg_ctl0 = '0;
    logic [31:0] seg_ctl1 = '0;
    logic [31:0] seg_ctl2 = '0;
    logic [1:0]  out_class;
    logic [35:0] out_paddr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seg_classifier uut (
        .clk(clk), .rst(rst), .vaddr(vaddr), .priv(priv), .err_level(err_level),
        .seg_ctl0(seg_ctl0), .seg_ctl1(seg_ctl1), .seg_ctl2(seg_ctl2),
        .out_class(out_class), .out_paddr(out_paddr)
    );

    function automatic logic [15:0] mk_half(input logic [6:0] base, input logic [2:0] am, input logic eu);
        return {base, 2'b00, am, eu, 3'b000};
    endfunction

    function automatic logic [1:0] exp_class(input logic [1:0] pr, input logic [2:0] am,
                                             input logic eu, input logic el);
        if (el && eu) return 2'd0;
        if (am == 3'd6) return 2'd2;
        case (pr)
            2'd0: return (am == 3'd1 || am == 3'd2 || am == 3'd3) ? 2'd1 : 2'd0;
            2'd1: begin
                if (am == 3'd0 || am == 3'd1) return 2'd2;
                if (am == 3'd2 || am == 3'd3 || am == 3'd4) return 2'd1;
                return 2'd0;
            end
            default: begin
                if (am == 3'd0 || am == 3'd1 || am == 3'd2 || am == 3'd5) return 2'd2;
                if (am == 3'd3 || am == 3'd4) return 2'd1;
                return 2'd0;
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] ec, input logic [35:0] ep);
        checks++;
        if (out_class !== ec || out_paddr !== ep) begin
            errors++;
            $display("FAIL %s: class=%0d paddr=%h expected class=%0d paddr=%h",
                     req, out_class, out_paddr, ec, ep);
        end
    endtask

    task automatic apply(input logic [31:0] va, input logic [1:0] pr, input logic el,
                         input logic [31:0] c0, input logic [31:0] c1, input logic [31:0] c2);
        @(negedge clk);
        vaddr = va; priv = pr; err_level = el;
        seg_ctl0 = c0; seg_ctl1 = c1; seg_ctl2 = c2;
        @(posedge clk);
        #1;
    endtask

    // R1: reset clears outputs while inputs would give a nonzero result
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        vaddr = 32'h8000_1000; priv = 2'd0; err_level = 1'b0;
        seg_ctl1 = {mk_half(7'h7F, 3'd0, 1'b0), 16'h0};
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", 2'd0, 36'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R4 R5 R6 R7 R9 R10: every AM code under every privilege code
    task automatic t_modes();
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 8; a++) begin
                logic [1:0]  ec;
                logic [35:0] ep;
                string       tag;
                ec = exp_class(2'(p), 3'(a), 1'b0, 1'b0);
                ep = (ec == 2'd0) ? ({7'h11, 29'h0} | 36'h0000_1234) : 36'h0;
                if (a == 6)      tag = "R7 reserved AM";
                else if (p == 0) tag = "R4 kernel";
                else if (p == 1) tag = "R5 supervisor";
                else             tag = "R6 user";
                apply(32'hC000_1234, 2'(p), 1'b0,
                      {mk_half(7'h11, 3'(a), 1'b0), 16'h0}, 32'h0, 32'h0);
                check($sformatf("%s priv=%0d am=%0d R10", tag, p, a), ec, ep);
            end
        end
    endtask

    // R3 R9: region boundaries pick the right half and offset mask
    task automatic t_segments();
        logic [31:0] c0, c1, c2;
        logic [31:0] addrs [12];
        c2 = {mk_half(7'h21, 3'd7, 1'b0), mk_half(7'h22, 3'd7, 1'b0)};
        c1 = {mk_half(7'h23, 3'd7, 1'b0), mk_half(7'h24, 3'd7, 1'b0)};
        c0 = {mk_half(7'h25, 3'd7, 1'b0), mk_half(7'h26, 3'd7, 1'b0)};
        addrs = '{32'h0000_0000, 32'h3FFF_FFFF, 32'h4000_0000, 32'h7FFF_FFFF,
                  32'h8000_0000, 32'h9FFF_FFFF, 32'hA000_0000, 32'hBFFF_FFFF,
                  32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF};
        for (int i = 0; i < 12; i++) begin
            logic [6:0]  b;
            logic [35:0] ep;
            if      (addrs[i] <  32'h4000_0000) b = 7'h21;
            else if (addrs[i] <  32'h8000_0000) b = 7'h22;
            else if (addrs[i] <  32'hA000_0000) b = 7'h23;
            else if (addrs[i] <  32'hC000_0000) b = 7'h24;
            else if (addrs[i] <  32'hE000_0000) b = 7'h25;
            else                                b = 7'h26;
            if (addrs[i] < 32'h8000_0000)
                ep = ({b, 29'h0} & ~36'h3FFF_FFFF) | (36'(addrs[i]) & 36'h3FFF_FFFF);
            else
                ep = {b, 29'h0} | (36'(addrs[i]) & 36'h1FFF_FFFF);
            apply(addrs[i], 2'd2, 1'b0, c0, c1, c2);
            check($sformatf("R3 R9 segment va=%h", addrs[i]), 2'd0, ep);
        end
        // R9: full base in a wide segment loses base bit 29
        apply(32'h7FFF_FFFF, 2'd0, 1'b0, 32'h0, 32'h0, {16'h0, mk_half(7'h7F, 3'd0, 1'b0)});
        check("R9 wide mask clears base bit", 2'd0, 36'hF_FFFF_FFFF);
    endtask

    // R8: EU override only with the error-level flag
    task automatic t_eu();
        apply(32'h0000_2000, 2'd2, 1'b1, 32'h0, 32'h0, {mk_half(7'h05, 3'd0, 1'b1), 16'h0});
        check("R8 EU with err_level user AM0", 2'd0, {7'h05, 29'h0} & ~36'h3FFF_FFFF | 36'h2000);
        apply(32'h0000_2000, 2'd2, 1'b0, 32'h0, 32'h0, {mk_half(7'h05, 3'd0, 1'b1), 16'h0});
        check("R8 EU without err_level", 2'd2, 36'h0);
        apply(32'h0000_2000, 2'd2, 1'b1, 32'h0, 32'h0, {mk_half(7'h05, 3'd0, 1'b0), 16'h0});
        check("R8 err_level without EU", 2'd2, 36'h0);
        apply(32'hE000_0040, 2'd0, 1'b1, {16'h0, mk_half(7'h09, 3'd2, 1'b1)}, 32'h0, 32'h0);
        check("R8 EU overrides kernel mapped", 2'd0, {7'h09, 29'h40});
        apply(32'hA000_0040, 2'd1, 1'b1, 32'h0, {16'h0, mk_half(7'h0A, 3'd6, 1'b1)}, 32'h0);
        check("R8 EU overrides reserved AM", 2'd0, {7'h0A, 29'h40});
    endtask

    // R2: one-cycle latency, outputs hold until the next edge
    task automatic t_latency();
        apply(32'h8000_0010, 2'd0, 1'b0, 32'h0, {mk_half(7'h30, 3'd0, 1'b0), 16'h0}, 32'h0);
        check("R2 first result", 2'd0, {7'h30, 29'h10});
        @(negedge clk);
        vaddr = 32'h8000_0020;
        seg_ctl1 = {mk_half(7'h30, 3'd1, 1'b0), 16'h0};
        #3;
        check("R2 holds before edge", 2'd0, {7'h30, 29'h10});
        @(posedge clk);
        #1;
        check("R2 new result after edge", 2'd1, 36'h0);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_segments();
        t_eu();
        t_latency();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule